// File: doc/BRIEF.md
# Clip Judgment History Unit

This block takes three floating-point components (x, y, z) and a scalar reference, and decides for each component whether it lies above plus the reference magnitude or below minus it. The six resulting judgment bits are shifted into a 24-bit history register. That register always holds the outcomes of the four most recent executions, and the newest result sits in the low six bits.

All decisions are made by integer compares on the raw single-precision bit patterns, so no floating-point arithmetic is needed. The sign of the reference is dropped to form its magnitude. A component whose exponent field is all zeros is treated as positive zero before it is compared. The unit takes one execute strobe per operation and never pushes back: an operation is taken on every cycle the strobe is high, including back-to-back cycles. The history register is the only output. It updates on the clock edge that samples the strobe.

Top module: `clip_judge_unit`

## Requirements
- R1: An active-low asynchronous reset clears the history register to zero.
- R2: In a cycle with the execute strobe low, the history register keeps its value whatever the data inputs do.
- R3: On each clock edge with the strobe high, the history becomes ((old << 6) | new) truncated to 24 bits. Bits shifted past bit 23 are lost.
- R4: Within the six new bits, bit 2k is the "above" judgment and bit 2k+1 the "below" judgment of lane k. Lane 0 is x (fs_i[31:0]), lane 1 is y (fs_i[63:32]) and lane 2 is z (fs_i[95:64]).
- R5: The above bit is set only when the component pattern, read as a signed 32-bit integer, is strictly greater than the magnitude pattern. A component equal to the magnitude sets nothing.
- R6: The below bit is set only when the component with its bit 31 inverted, read as a signed integer, is strictly greater than the magnitude pattern. A component equal to minus the magnitude sets nothing.
- R7: The magnitude is ref_w_i with bit 31 cleared, so the sign of the reference does not change any judgment.
- R8: A component whose bits [30:23] are all zero is replaced by +0 before both compares, so it sets neither of its bits. The reference is not flushed.
- R9: Executions on consecutive cycles are each accepted. There is no ready signal and no back-pressure.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| exec_i | input | 1 | Execute strobe, one operation per high cycle |
| fs_i | input | 96 | Components: x in [31:0], y in [63:32], z in [95:64] |
| ref_w_i | input | 32 | Reference value; only its magnitude is used |
| clip_o | output | 24 | Judgment history, newest six bits lowest |

## Verification
The assertions assume that the strobe and data inputs are stable around the sampling edge and that reset is released synchronously to the clock. The bench meets both by driving every input on the falling edge. The flush and pair-exclusion properties rely on the magnitude never being negative as a signed integer. That holds for any reference value because bit 31 is cleared, so the stimulus is free to use negative and denormal references. The directed vectors include exact-equality and minimum-normal patterns, which place each compare right at its boundary.

// File: rtl/clip_pkg.sv
package clip_pkg;
  localparam int FLOAT_W  = 32;
  localparam int EXP_LSB  = 23;
  localparam int EXP_W    = 8;
  localparam int EXP_MSB  = EXP_LSB + EXP_W - 1;
  localparam int SIGN_BIT = FLOAT_W - 1;
  localparam logic [FLOAT_W-1:0] SIGN_MASK = {1'b1, {(FLOAT_W-1){1'b0}}};

  typedef struct packed {
    logic below;
    logic above;
  } judge_pair_t;
endpackage

// File: rtl/clip_lane_judge.sv
module clip_lane_judge
  import clip_pkg::*;
(
  input  logic [FLOAT_W-1:0] comp_i,
  input  logic [FLOAT_W-1:0] mag_i,
  output judge_pair_t        pair_o
);
  logic               exp_zero;
  logic [FLOAT_W-1:0] flushed;
  logic [FLOAT_W-1:0] negated;

  // exponent-zero components act as +0
  always_comb begin
    exp_zero = (comp_i[EXP_MSB:EXP_LSB] == '0);
    flushed  = exp_zero ? '0 : comp_i;
    negated  = flushed ^ SIGN_MASK;
  end

  always_comb begin
    pair_o.above = $signed(flushed) > $signed(mag_i);
    pair_o.below = $signed(negated) > $signed(mag_i);
  end
endmodule

// File: rtl/clip_history.sv
module clip_history #(
  parameter int JUDGE_W = 6,
  parameter int DEPTH   = 4,
  localparam int HIST_W = JUDGE_W * DEPTH
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shift_i,
  input  logic [JUDGE_W-1:0] judge_i,
  output logic [HIST_W-1:0]  hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       hist_q <= '0;
    else if (shift_i) hist_q <= {hist_q[HIST_W-JUDGE_W-1:0], judge_i};
  end

  assign hist_o = hist_q;
endmodule

// File: rtl/clip_judge_unit.sv
module clip_judge_unit
  import clip_pkg::*;
#(
  parameter int LANES = 3,
  parameter int DEPTH = 4,
  localparam int JUDGE_W = 2 * LANES,
  localparam int HIST_W  = JUDGE_W * DEPTH
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     exec_i,
  input  logic [LANES*FLOAT_W-1:0] fs_i,
  input  logic [FLOAT_W-1:0]       ref_w_i,
  output logic [HIST_W-1:0]        clip_o
);
  logic [FLOAT_W-1:0] mag;
  judge_pair_t        pairs [LANES];
  logic [JUDGE_W-1:0] judge;

  assign mag = ref_w_i & ~SIGN_MASK;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    clip_lane_judge u_lane (
      .comp_i (fs_i[k*FLOAT_W +: FLOAT_W]),
      .mag_i  (mag),
      .pair_o (pairs[k])
    );
    assign judge[2*k]   = pairs[k].above;
    assign judge[2*k+1] = pairs[k].below;
  end

  clip_history #(.JUDGE_W(JUDGE_W), .DEPTH(DEPTH)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_i (exec_i),
    .judge_i (judge),
    .hist_o  (clip_o)
  );
endmodule

// File: rtl/clip_judge_chk.sv
module clip_judge_chk
  import clip_pkg::*;
#(
  parameter int LANES = 3,
  parameter int DEPTH = 4,
  localparam int JUDGE_W = 2 * LANES,
  localparam int HIST_W  = JUDGE_W * DEPTH
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     exec_i,
  input logic [LANES*FLOAT_W-1:0] fs_i,
  input logic [FLOAT_W-1:0]       ref_w_i,
  input logic [HIST_W-1:0]        clip_o
);
  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_i |=> $stable(clip_o));

  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    exec_i |=> clip_o[HIST_W-1:JUDGE_W] == $past(clip_o[HIST_W-JUDGE_W-1:0]));

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    // R5 R6: magnitude is never negative, so both bits of a lane cannot be set
    assert_pair_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
      exec_i |=> !(clip_o[2*k] && clip_o[2*k+1]));

    assert_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && fs_i[k*FLOAT_W+EXP_LSB +: EXP_W] == '0) |=> clip_o[2*k+1 -: 2] == 2'b00);

    // R7: sign of reference never decides; zero magnitude with nonzero normal comp sets exactly one bit
    assert_zero_mag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_i && (ref_w_i & ~SIGN_MASK) == '0 && fs_i[k*FLOAT_W+EXP_LSB +: EXP_W] != '0)
        |=> $countones(clip_o[2*k+1 -: 2]) == 1);
  end
endmodule

bind clip_judge_unit clip_judge_chk #(.LANES(LANES), .DEPTH(DEPTH)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .exec_i  (exec_i),
  .fs_i    (fs_i),
  .ref_w_i (ref_w_i),
  .clip_o  (clip_o)
);

// File: tb/tb_clip_judge_unit.sv
`timescale 1ns/1ps
module tb_clip_judge_unit;
  localparam logic [31:0] P1 = 32'h3F80_0000, N1 = 32'hBF80_0000;
  localparam logic [31:0] P2 = 32'h4000_0000, N2 = 32'hC000_0000;
  localparam logic [31:0] PH = 32'h3F00_0000;

  logic        clk = 0, rst_n = 0, exec_i = 0;
  logic [95:0] fs_i = '0;
  logic [31:0] ref_w_i = '0;
  logic [23:0] clip_o;
  logic [23:0] model = '0;
  int nchk = 0, nfail = 0;

  clip_judge_unit dut (.clk(clk), .rst_n(rst_n), .exec_i(exec_i),
                       .fs_i(fs_i), .ref_w_i(ref_w_i), .clip_o(clip_o));

  always #2.5 clk = ~clk;

  task automatic check(string req, logic [23:0] act, logic [23:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: clip_o=%06h expected %06h", req, act, exp);
    end
  endtask

  // one execution; bits is the hand-derived judgment for this vector
  task automatic run1(string req, logic [31:0] x, y, z, w, logic [5:0] bits);
    @(negedge clk);
    fs_i = {z, y, x}; ref_w_i = w; exec_i = 1;
    @(negedge clk);
    exec_i = 0;
    model = {model[17:0], bits};
    check(req, clip_o, model);
  endtask

  task automatic t_reset();
    check("R1 reset", clip_o, 24'h0);
  endtask

  task automatic t_basic();
    run1("R4 x above, y below", P2, N2, PH, P1, 6'b00_10_01);
    run1("R4 z above, x below", N2, PH, P2, P1, 6'b01_00_10);
  endtask

  task automatic t_strict();
    run1("R5 R6 equal to +-|w|", P1, N1, P1, P1, 6'b0);
    run1("R5 just above", 32'h3F80_0001, 32'hBF80_0001, PH, P1, 6'b00_10_01);
  endtask

  task automatic t_sign_w();
    run1("R7 negative reference", P2, N2, PH, N1, 6'b00_10_01);
  endtask

  task automatic t_flush();
    run1("R8 denormals flushed", 32'h0000_0005, 32'h8000_0007, 32'h0, 32'h0000_0001, 6'b0);
    run1("R8 min normal not flushed", 32'h0080_0000, 32'h8080_0000, 32'h0, 32'h0000_0001, 6'b00_10_01);
  endtask

  task automatic t_hold();
    @(negedge clk);
    fs_i = {P2, N2, P2}; ref_w_i = PH;
    repeat (3) @(negedge clk);
    check("R2 hold without strobe", clip_o, model);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < 5; i++)
      run1("R3 shift and drop", (i % 2) ? N2 : P2, PH, PH, P1, (i % 2) ? 6'b10 : 6'b01);
  endtask

  task automatic t_b2b();
    @(negedge clk);
    fs_i = {PH, PH, P2}; ref_w_i = P1; exec_i = 1;
    @(negedge clk);
    model = {model[17:0], 6'b00_00_01};
    check("R9 back-to-back first", clip_o, model);
    fs_i = {N2, PH, PH};
    @(negedge clk);
    model = {model[17:0], 6'b10_00_00};
    check("R9 back-to-back second", clip_o, model);
    fs_i = {PH, P2, PH};
    @(negedge clk);
    exec_i = 0;
    model = {model[17:0], 6'b00_01_00};
    check("R9 back-to-back third", clip_o, model);
  endtask

  task automatic t_reset_mid();
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    model = '0;
    check("R1 reset mid-run", clip_o, 24'h0);
    rst_n = 1;
  endtask

  initial begin
    #1_000_000;
    nfail++; nchk++;
    $display("FAIL watchdog: expired, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_basic();
    t_strict();
    t_sign_w();
    t_flush();
    t_hold();
    t_overflow();
    t_b2b();
    t_reset_mid();
    t_basic();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule